// File: doc/BRIEF.md
# LAPD Message Frame Transmitter

This block sends one LAPD-style message frame each time software asks for it. The host fills an internal payload buffer, sets the payload length, the address fields and the control octet, then writes the start bit. The block serializes the whole frame onto a one-bit data-link stream. The frame is an opening flag, two address octets, a control octet, the payload, a 16-bit frame check sequence and a closing flag. The stream is bit-stuffed and is paced by a slot strobe from the overhead inserter.

The host learns that the next message can be loaded in one of two ways: it polls a busy bit, or it waits for a completion status bit that clears when read. The interrupt output follows that status whenever the interrupt enable is set.

The bus is one address space of `ADDR_W` bits. Addresses below `BUF_DEPTH` write payload byte N at address N. Registers sit at `BUF_DEPTH + offset`:
- Offset 0 is control/status. Bit 0 is start and is write-only. Bit 1 is the interrupt enable. Bit 2 is busy and is read-only. Bit 3 is done, which clears when read.
- Offset 1 is the payload length.
- Offset 2 holds the address octet: bits 5:0 are SAPI and bit 6 is C/R.
- Offset 3 holds the TEI in bits 6:0.
- Offset 4 is the control octet.

Read data appears on `bus_rdata` one cycle after `bus_rd`.

Top module: `lapd_frame_tx`

## Requirements
- R1: Before stuffing, a frame is the octet 0x7E, then {SAPI,C/R,0}, then {TEI,1}, then the control octet, then the payload bytes from buffer index 0 upward, then FCS low octet, then FCS high octet, then 0x7E. Every octet is sent least-significant bit first.
- R2: The FCS is computed over the three header octets and the payload, fed LSB first. It uses the CRC-16-CCITT polynomial in reflected form (0x8408) with the register preset to 0xFFFF, and the result is complemented before it is sent.
- R3: Between the flags, a 0 is inserted after every run of five 1s. Inserted zeros are not counted in the run. The two flags are never stuffed.
- R4: Writing 1 to control bit 0 while the block is idle starts a frame. The stream begins with the opening flag.
- R5: A start write made while busy is ignored. The frame in progress is unchanged and no second frame follows it.
- R6: Control bit 2 (busy) reads 1 from the cycle after an accepted start until the last closing-flag bit has been emitted, and 0 otherwise.
- R7: Control bit 3 (done) is set when a frame completes. A read of the control register returns it and then clears it, so the next read returns 0.
- R8: `irq` is high exactly when done is set and control bit 1 (enable) is 1, and drops the cycle after the status is read.
- R9: `dl_vld` pulses for one cycle carrying one frame bit in the cycle after each `dl_slot` strobe taken while busy. Strobes taken while idle produce nothing.
- R10: The length register holds 0 to `BUF_DEPTH`. Writes above `BUF_DEPTH` store `BUF_DEPTH`.
- R11: After reset the block is idle, control/status reads 0, and both `irq` and `dl_vld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| dl_slot | input | 1 | Slot strobe: one bit may be sent |
| dl_bit | output | 1 | Serial frame bit |
| dl_vld | output | 1 | `dl_bit` carries a frame bit |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume that the host leaves the length, the header registers and the payload buffer unchanged while a frame is in flight. They also assume that `dl_slot` is a plain one-cycle strobe that may arrive every cycle or with gaps. The stimulus follows both assumptions. Every frame is configured and loaded before its start write, and the only bus traffic during a frame is status reads and one deliberate repeated start. The slot generator runs with gaps of one to four cycles, including while the block is idle.

// File: rtl/lapd_tx_pkg.sv
package lapd_tx_pkg;
  localparam logic [7:0]  FLAG_OCTET = 8'h7E;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam int unsigned STUFF_RUN  = 5;

  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_LEN  = 1;
  localparam int unsigned OFS_ADR  = 2;
  localparam int unsigned OFS_TEI  = 3;
  localparam int unsigned OFS_CMD  = 4;

  typedef enum logic [3:0] {
    SEG_IDLE, SEG_OPEN, SEG_ADR1, SEG_ADR2, SEG_CMD,
    SEG_DATA, SEG_FCS1, SEG_FCS2, SEG_CLOSE
  } seg_e;
endpackage

// File: rtl/lapd_tx_buf.sv
module lapd_tx_buf #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lapd_tx_fcs.sv
module lapd_tx_fcs
  import lapd_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        init,
  input  logic        upd,
  input  logic        din,
  output logic [15:0] crc_q,
  output logic [15:0] crc_nxt
);
  logic fb;

  always_comb begin
    fb      = crc_q[0] ^ din;
    crc_nxt = {1'b0, crc_q[15:1]} ^ (fb ? CRC_POLY_R : 16'h0000);
  end

  always_ff @(posedge clk) begin
    if (rst || init) crc_q <= CRC_PRESET;
    else if (upd)    crc_q <= crc_nxt;
  end
endmodule

// File: rtl/lapd_tx_regs.sv
module lapd_tx_regs
  import lapd_tx_pkg::*;
#(
  parameter int unsigned BUF_DEPTH = 128,
  parameter int unsigned ADDR_W    = $clog2(BUF_DEPTH) + 1,
  parameter int unsigned LEN_W     = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              busy_i,
  input  logic              done_i,
  output logic              start_o,
  output logic              buf_we_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [5:0]        sapi_o,
  output logic              cr_o,
  output logic [6:0]        tei_o,
  output logic [7:0]        cmd_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] REG_BASE = ADDR_W'(BUF_DEPTH);

  logic              reg_sel;
  logic [ADDR_W-1:0] ofs;
  logic              wr_ctrl, rd_ctrl;
  logic              ien_q, stat_q;
  logic              ien_nxt, stat_nxt;

  always_comb begin
    reg_sel  = (bus_addr >= REG_BASE);
    ofs      = bus_addr - REG_BASE;
    wr_ctrl  = bus_wr && reg_sel && (ofs == ADDR_W'(OFS_CTRL));
    rd_ctrl  = bus_rd && reg_sel && (ofs == ADDR_W'(OFS_CTRL));
    buf_we_o = bus_wr && !reg_sel;
    start_o  = wr_ctrl && bus_wdata[0] && !busy_i;
    ien_nxt  = wr_ctrl ? bus_wdata[1] : ien_q;
    stat_nxt = done_i || (stat_q && !rd_ctrl);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q  <= 1'b0;
      stat_q <= 1'b0;
      irq_o  <= 1'b0;
      len_o  <= '0;
      sapi_o <= '0;
      cr_o   <= 1'b0;
      tei_o  <= '0;
      cmd_o  <= '0;
    end else begin
      ien_q  <= ien_nxt;
      stat_q <= stat_nxt;
      irq_o  <= ien_nxt && stat_nxt;
      if (bus_wr && reg_sel) begin
        case (ofs)
          ADDR_W'(OFS_LEN): begin
            if (int'(bus_wdata) > int'(BUF_DEPTH)) len_o <= LEN_W'(BUF_DEPTH);
            else                                   len_o <= LEN_W'(bus_wdata);
          end
          ADDR_W'(OFS_ADR): begin
            sapi_o <= bus_wdata[5:0];
            cr_o   <= bus_wdata[6];
          end
          ADDR_W'(OFS_TEI): tei_o <= bus_wdata[6:0];
          ADDR_W'(OFS_CMD): cmd_o <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= 8'h00;
    end else if (bus_rd) begin
      bus_rdata <= 8'h00;
      if (reg_sel) begin
        case (ofs)
          ADDR_W'(OFS_CTRL): bus_rdata <= {4'b0000, stat_q, busy_i, ien_q, 1'b0};
          ADDR_W'(OFS_LEN):  bus_rdata <= 8'(len_o);
          ADDR_W'(OFS_ADR):  bus_rdata <= {1'b0, cr_o, sapi_o};
          ADDR_W'(OFS_TEI):  bus_rdata <= {1'b0, tei_o};
          ADDR_W'(OFS_CMD):  bus_rdata <= cmd_o;
          default:           bus_rdata <= 8'h00;
        endcase
      end
    end
  end
endmodule

// File: rtl/lapd_tx_engine.sv
module lapd_tx_engine
  import lapd_tx_pkg::*;
#(
  parameter int unsigned BUF_DEPTH = 128,
  parameter int unsigned AW        = $clog2(BUF_DEPTH),
  parameter int unsigned LEN_W     = $clog2(BUF_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             slot_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [5:0]       sapi_i,
  input  logic             cr_i,
  input  logic [6:0]       tei_i,
  input  logic [7:0]       cmd_i,
  output logic [AW-1:0]    rd_addr_o,
  input  logic [7:0]       rd_data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             bit_o,
  output logic             vld_o
);
  localparam int unsigned RUN_W = $clog2(STUFF_RUN + 1);

  seg_e             seg_q, seg_nxt;
  logic [7:0]       sh_q, oct_nxt;
  logic [2:0]       bit_q;
  logic [RUN_W-1:0] ones_q;
  logic             stuff_q;
  logic [LEN_W-1:0] pidx_q, pidx_nxt;
  logic             emit, flag_seg, crc_seg, octet_end, cur_bit;
  logic [15:0]      crc_q, crc_nxt;

  always_comb begin
    emit      = slot_i && (seg_q != SEG_IDLE);
    flag_seg  = (seg_q == SEG_OPEN) || (seg_q == SEG_CLOSE);
    crc_seg   = (seg_q == SEG_ADR1) || (seg_q == SEG_ADR2) ||
                (seg_q == SEG_CMD)  || (seg_q == SEG_DATA);
    octet_end = emit && !stuff_q && (bit_q == 3'd7);
    cur_bit   = stuff_q ? 1'b0 : sh_q[0];
    rd_addr_o = pidx_q[AW-1:0];
    busy_o    = (seg_q != SEG_IDLE);
  end

  lapd_tx_fcs u_fcs (
    .clk     (clk),
    .rst     (rst),
    .init    (start_i && (seg_q == SEG_IDLE)),
    .upd     (emit && !stuff_q && crc_seg),
    .din     (sh_q[0]),
    .crc_q   (crc_q),
    .crc_nxt (crc_nxt)
  );

  always_comb begin
    seg_nxt  = seg_q;
    oct_nxt  = sh_q;
    pidx_nxt = pidx_q;
    case (seg_q)
      SEG_OPEN: begin seg_nxt = SEG_ADR1; oct_nxt = {sapi_i, cr_i, 1'b0}; end
      SEG_ADR1: begin seg_nxt = SEG_ADR2; oct_nxt = {tei_i, 1'b1}; end
      SEG_ADR2: begin seg_nxt = SEG_CMD;  oct_nxt = cmd_i; end
      SEG_CMD, SEG_DATA: begin
        if (pidx_q == len_i) begin
          seg_nxt = SEG_FCS1;
          oct_nxt = ~crc_nxt[7:0];
        end else begin
          seg_nxt  = SEG_DATA;
          oct_nxt  = rd_data_i;
          pidx_nxt = pidx_q + 1'b1;
        end
      end
      SEG_FCS1:  begin seg_nxt = SEG_FCS2;  oct_nxt = ~crc_q[15:8]; end
      SEG_FCS2:  begin seg_nxt = SEG_CLOSE; oct_nxt = FLAG_OCTET; end
      SEG_CLOSE: begin seg_nxt = SEG_IDLE;  oct_nxt = 8'h00; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q   <= SEG_IDLE;
      sh_q    <= 8'h00;
      bit_q   <= 3'd0;
      ones_q  <= '0;
      stuff_q <= 1'b0;
      pidx_q  <= '0;
      done_o  <= 1'b0;
      bit_o   <= 1'b0;
      vld_o   <= 1'b0;
    end else begin
      vld_o  <= emit;
      done_o <= 1'b0;
      if (emit) bit_o <= cur_bit;
      if (seg_q == SEG_IDLE) begin
        if (start_i) begin
          seg_q   <= SEG_OPEN;
          sh_q    <= FLAG_OCTET;
          bit_q   <= 3'd0;
          ones_q  <= '0;
          stuff_q <= 1'b0;
          pidx_q  <= '0;
        end
      end else if (emit) begin
        if (stuff_q) begin
          stuff_q <= 1'b0;
          ones_q  <= '0;
        end else begin
          if (flag_seg || !sh_q[0]) begin
            ones_q <= '0;
          end else if (ones_q == RUN_W'(STUFF_RUN - 1)) begin
            ones_q  <= '0;
            stuff_q <= 1'b1;
          end else begin
            ones_q <= ones_q + 1'b1;
          end
          if (octet_end) begin
            seg_q  <= seg_nxt;
            sh_q   <= oct_nxt;
            pidx_q <= pidx_nxt;
            bit_q  <= 3'd0;
            if (seg_q == SEG_CLOSE) done_o <= 1'b1;
          end else begin
            sh_q  <= {1'b0, sh_q[7:1]};
            bit_q <= bit_q + 3'd1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/lapd_frame_tx.sv
module lapd_frame_tx
  import lapd_tx_pkg::*;
#(
  parameter int unsigned BUF_DEPTH = 128,
  parameter int unsigned ADDR_W    = $clog2(BUF_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              dl_slot,
  output logic              dl_bit,
  output logic              dl_vld,
  output logic              irq
);
  localparam int unsigned AW    = $clog2(BUF_DEPTH);
  localparam int unsigned LEN_W = $clog2(BUF_DEPTH + 1);

  logic             start_w, done_w, busy_w, buf_we;
  logic [LEN_W-1:0] len_w;
  logic [5:0]       sapi_w;
  logic             cr_w;
  logic [6:0]       tei_w;
  logic [7:0]       cmd_w, rd_data;
  logic [AW-1:0]    rd_addr;

  lapd_tx_regs #(.BUF_DEPTH(BUF_DEPTH), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy_i(busy_w), .done_i(done_w),
    .start_o(start_w), .buf_we_o(buf_we), .len_o(len_w), .sapi_o(sapi_w),
    .cr_o(cr_w), .tei_o(tei_w), .cmd_o(cmd_w), .irq_o(irq)
  );

  lapd_tx_buf #(.DEPTH(BUF_DEPTH), .AW(AW)) u_buf (
    .clk(clk), .we(buf_we), .waddr(bus_addr[AW-1:0]), .wdata(bus_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

  lapd_tx_engine #(.BUF_DEPTH(BUF_DEPTH), .AW(AW), .LEN_W(LEN_W)) u_eng (
    .clk(clk), .rst(rst), .start_i(start_w), .slot_i(dl_slot), .len_i(len_w),
    .sapi_i(sapi_w), .cr_i(cr_w), .tei_i(tei_w), .cmd_i(cmd_w),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .busy_o(busy_w), .done_o(done_w),
    .bit_o(dl_bit), .vld_o(dl_vld)
  );
endmodule

// File: rtl/lapd_frame_tx_chk.sv
module lapd_frame_tx_chk (
  input logic clk,
  input logic rst,
  input logic dl_slot,
  input logic dl_bit,
  input logic dl_vld,
  input logic busy,
  input logic start,
  input logic done
);
  logic [2:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= 3'd0;
    else if (dl_vld) run_q <= dl_bit ? ((run_q == 3'd7) ? run_q : run_q + 3'd1) : 3'd0;
  end

  // R9: a frame bit only follows a slot strobe
  a_r9_vld_after_slot: assert property (@(posedge clk) disable iff (rst)
    dl_vld |-> $past(dl_slot));

  // R3: no run of more than six ones on the line (six only inside a flag)
  a_r3_ones_run: assert property (@(posedge clk) disable iff (rst)
    (dl_vld && dl_bit) |-> (run_q < 3'd6));

  // R6: busy rises only after an accepted start
  a_r6_busy_on_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R6: busy falls together with the completion pulse
  a_r6_busy_ends_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
endmodule

bind lapd_frame_tx lapd_frame_tx_chk u_chk (
  .clk(clk), .rst(rst), .dl_slot(dl_slot), .dl_bit(dl_bit), .dl_vld(dl_vld),
  .busy(busy_w), .start(start_w), .done(done_w)
);

// File: tb/lapd_frame_tx_bench.sv
`timescale 1ns/1ps
module lapd_frame_tx_bench;
  localparam int DEPTH = 128;
  localparam int AWB   = 8;
  localparam int BASE  = DEPTH;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AWB-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic dl_slot = 1'b0, dl_bit, dl_vld, irq;

  int total = 0, bad = 0;
  int gap = 1, sc = 0;
  int ngot = 0, nexp = 0;
  logic got [0:16383];
  logic exp_b [0:2047];
  logic [7:0] pay [0:127];
  logic [5:0] h_sapi; logic h_cr; logic [6:0] h_tei; logic [7:0] h_cmd;

  lapd_frame_tx #(.BUF_DEPTH(DEPTH)) u_lapd_frame_tx (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dl_slot(dl_slot),
    .dl_bit(dl_bit), .dl_vld(dl_vld), .irq(irq)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    sc = sc + 1;
    if (sc >= gap) begin sc = 0; dl_slot = 1'b1; end
    else dl_slot = 1'b0;
  end

  always @(negedge clk) begin
    if (!rst && dl_vld) begin
      if (ngot < 16384) got[ngot] = dl_bit;
      ngot = ngot + 1;
    end
  end

  task automatic report;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total = total + 1; bad = bad + 1;
    $display("FAIL watchdog: actual=hung expected=finish");
    report();
  end

  task automatic check(input string req, input int act, input int expv);
    total = total + 1;
    if (act !== expv) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = AWB'(a); bus_wdata = 8'(d);
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = AWB'(a);
    @(negedge clk); bus_rd = 1'b0; d = int'(bus_rdata);
  endtask

  task automatic push(input logic b);
    exp_b[nexp] = b; nexp = nexp + 1;
  endtask

  task automatic build_exp(input int len);
    logic [7:0] oc [0:131];
    logic [15:0] crc;
    int n, run;
    logic fb;
    oc[0] = {h_sapi, h_cr, 1'b0}; oc[1] = {h_tei, 1'b1}; oc[2] = h_cmd;
    for (int i = 0; i < len; i++) oc[3+i] = pay[i];
    n = 3 + len;
    crc = 16'hFFFF;
    for (int k = 0; k < n; k++)
      for (int b = 0; b < 8; b++) begin
        fb = crc[0] ^ oc[k][b];
        crc = crc >> 1;
        if (fb) crc = crc ^ 16'h8408;
      end
    crc = ~crc;
    nexp = 0;
    for (int b = 0; b < 8; b++) push(b != 0 && b != 7);
    run = 0;
    for (int k = 0; k < n + 2; k++)
      for (int b = 0; b < 8; b++) begin
        logic v;
        v = (k < n) ? oc[k][b] : ((k == n) ? crc[b] : crc[8+b]);
        push(v);
        run = v ? run + 1 : 0;
        if (run == 5) begin push(1'b0); run = 0; end
      end
    for (int b = 0; b < 8; b++) push(b != 0 && b != 7);
  endtask

  task automatic run_frame(input int len, input int kind, input int g, input int ien,
                           input int restart, input string tag);
    int base, d, mism, wait_c;
    for (int i = 0; i < len; i++) begin
      case (kind)
        0: pay[i] = 8'(i);
        1: pay[i] = 8'hFF;
        2: pay[i] = 8'((i * 37 + 11) & 255);
        default: pay[i] = 8'h00;
      endcase
      wr(i, int'(pay[i]));
    end
    wr(BASE + 1, len);
    wr(BASE + 2, int'({1'b0, h_cr, h_sapi}));
    wr(BASE + 3, int'({1'b0, h_tei}));
    wr(BASE + 4, int'(h_cmd));
    gap = g;
    build_exp(len);
    base = ngot;
    wr(BASE + 0, (ien << 1) | 1);
    repeat (10) @(negedge clk);
    rd(BASE + 0, d);
    check({tag, " R6 busy during frame"}, (d >> 2) & 1, 1);
    if (restart != 0) begin
      wr(BASE + 0, (ien << 1) | 1);
      repeat (30) @(negedge clk);
      wr(BASE + 0, (ien << 1) | 1);
    end
    wait_c = 0;
    while ((ngot - base) < nexp && wait_c < 30000) begin
      @(negedge clk); wait_c++;
    end
    repeat (60) @(negedge clk);
    check({tag, " R1 R5 bit count"}, ngot - base, nexp);
    mism = -1;
    for (int i = 0; i < nexp; i++)
      if (mism < 0 && got[base+i] !== exp_b[i]) mism = i;
    check({tag, " R1 R2 R3 first mismatching bit"}, mism, -1);
    check({tag, " R8 irq after done"}, int'(irq), ien);
    rd(BASE + 0, d);
    check({tag, " R6 R7 status after frame"}, d, 8 | (ien << 1));
    check({tag, " R8 irq after read"}, int'(irq), 0);
    rd(BASE + 0, d);
    check({tag, " R7 done cleared by read"}, (d >> 3) & 1, 0);
  endtask

  initial begin
    int d, n0;
    h_sapi = 6'h10; h_cr = 1'b0; h_tei = 7'h21; h_cmd = 8'h03;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 irq after reset", int'(irq), 0);
    check("R11 dl_vld after reset", int'(dl_vld), 0);
    rd(BASE + 0, d);
    check("R11 control after reset", d, 0);

    wr(BASE + 1, 200);
    rd(BASE + 1, d);
    check("R10 length saturates", d, 128);
    wr(BASE + 1, 77);
    rd(BASE + 1, d);
    check("R10 length in range", d, 77);

    n0 = ngot;
    repeat (50) @(negedge clk);
    check("R9 idle slots emit nothing", ngot - n0, 0);

    run_frame(0,   0, 1, 1, 0, "len0");
    run_frame(1,   1, 1, 0, 0, "len1_ff");
    run_frame(5,   0, 3, 1, 1, "len5_restart");
    run_frame(17,  2, 2, 1, 0, "len17");
    run_frame(128, 1, 1, 1, 0, "len128_ff");
    run_frame(64,  3, 4, 0, 0, "len64_zero");
    h_sapi = 6'h3F; h_cr = 1'b1; h_tei = 7'h7F; h_cmd = 8'hFF;
    run_frame(3,   1, 2, 1, 0, "hdr_ones R4");

    n0 = ngot;
    gap = 1;
    repeat (50) @(negedge clk);
    check("R9 R5 no output after frames", ngot - n0, 0);
    report();
  end
endmodule